// File: doc/BRIEF.md
# Stepped-Gain AGC with Delay-Matched Compensation

This block closes a gain loop around an external amplifier whose gain moves in 6 dB steps ahead of the ADC. It sets the gain through a 3-bit code, with a strobe that marks each change. It also takes out the effect of those steps from the digitised samples, so the stream sent downstream keeps a constant scale. A loop gain, a reference level and a mode select set the loop. The loop can run on its own or be held at a fixed step. Each receive channel uses its own instance, and all instances are fed the same control inputs.

The analog gain change reaches the samples only after the ADC pipeline latency. For that reason the code used for compensation comes from a delay line, and the delay is programmable from 0 to 15 sample clocks. Every clock edge carries one sample.

Top module: `agc_comp`

## Requirements
- R1: While rst_ni is low, gain_code_o is 0, gain_stb_o is 0 and comp_o is 0.
- R2: In fixed mode (fixed_mode_i = 1), each edge loads the integrator with fixed_code_i in its top 3 bits and zeros below. After that edge, gain_code_o equals fixed_code_i.
- R3: In continuous mode, each edge updates the 16-bit integrator to acc - (acc >> 8) + ((ref_lvl_i - |smp_i|) >>> loop_shift_i). The shift is arithmetic. gain_code_o is integrator bits [15:13].
- R4: The integrator saturates at 0 and at 65535 and never wraps. A sustained small input drives the code to 7, and a sustained large input drives it to 0.
- R5: gain_stb_o is 1 in exactly those cycles where gain_code_o differs from its value in the previous cycle.
- R6: On each edge, comp_o is loaded with the sign-extended smp_i shifted left by (7 - g) bits into 21 bits. Here g is the selected compensation code.
- R7: With comp_dly_i = D, g is the gain_code_o value from D cycles before the current cycle. D = 0 uses the current value.
- R8: At code 0 the full 7-bit shift holds the extreme samples without overflow: -8192 gives -1048576 and 8191 gives 1048448. At code 7, comp_o equals the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_i | input | 14 | Signed ADC sample |
| fixed_mode_i | input | 1 | 1 = hold fixed step, 0 = continuous loop |
| fixed_code_i | input | 3 | Gain step used in fixed mode |
| ref_lvl_i | input | 13 | Target magnitude level |
| loop_shift_i | input | 4 | Right shift applied to the loop error |
| comp_dly_i | input | 4 | Compensation delay in sample clocks |
| gain_code_o | output | 3 | Gain code to the external amplifier |
| gain_stb_o | output | 1 | One-cycle pulse on a code change |
| comp_o | output | 21 | Signed gain-compensated sample |

## Verification
The bench targets three kinds of error.

- **Delay alignment.** It exercises delays of 0, 1, 7 and 15 while the fixed code changes under random samples. An off-by-one in the delay taps would apply each correction one sample early or late around every step.
- **Shift extremes.** It drives the full-scale samples at codes 0 and 7. A design that used a narrower result or a logical shift would lose the sign or wrap at the most negative sample.
- **Saturation and strobe.** It holds the loop at both saturation limits long enough that a wrapping accumulator would jump from code 7 to 0. It also checks that the strobe stays low while the code is steady, which catches a strobe that fires on every loop update.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
  typedef logic [CODE_W-1:0] gain_code_t;
endpackage

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int unsigned IN_W    = 14,
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned SH_W    = 4,
  parameter int unsigned LEAK_SH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [IN_W-1:0] smp_i,
  input  logic                   fixed_mode_i,
  input  gain_code_t             fixed_code_i,
  input  logic [IN_W-2:0]        ref_lvl_i,
  input  logic [SH_W-1:0]        loop_shift_i,
  output gain_code_t             code_o,
  output logic                   stb_o
);
  localparam int unsigned ERR_W = IN_W + 2;
  localparam int unsigned SUM_W = ACC_W + 2;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q, acc_d, leak;
  logic [IN_W-1:0]  mag;
  logic signed [ERR_W-1:0] err_s, step_s;
  logic signed [SUM_W-1:0] sum_s;
  gain_code_t prev_q;

  assign mag    = smp_i[IN_W-1] ? IN_W'(-smp_i) : IN_W'(smp_i);
  assign err_s  = $signed({3'b000, ref_lvl_i}) - $signed({2'b00, mag});
  assign step_s = err_s >>> loop_shift_i;
  assign leak   = acc_q >> LEAK_SH;
  assign sum_s  = $signed({2'b00, acc_q}) - $signed({2'b00, leak})
                + $signed({{(SUM_W-ERR_W){step_s[ERR_W-1]}}, step_s});

  always_comb begin
    if (fixed_mode_i)
      acc_d = {fixed_code_i, {(ACC_W-CODE_W){1'b0}}};
    else if (sum_s < 0)
      acc_d = '0;
    else if (sum_s > $signed({2'b00, ACC_MAX}))
      acc_d = ACC_MAX;
    else
      acc_d = sum_s[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      prev_q <= '0;
    end else begin
      acc_q  <= acc_d;
      prev_q <= code_o;
    end
  end

  assign code_o = acc_q[ACC_W-1 -: CODE_W];
  assign stb_o  = (code_o != prev_q);

  p_fixed_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_mode_i |=> code_o == $past(fixed_code_i));
  p_no_wrap_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fixed_mode_i && !step_s[ERR_W-1]) |=>
      ({1'b0, acc_q} + {1'b0, $past(leak)}) >= {1'b0, $past(acc_q)});
  p_no_wrap_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fixed_mode_i && step_s[ERR_W-1]) |=> acc_q <= $past(acc_q));
  p_stb_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o == (code_o != $past(code_o)));
endmodule

// File: rtl/agc_delay.sv
module agc_delay
  import agc_pkg::*;
#(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gain_code_t       code_i,
  input  logic [DLY_W-1:0] dly_i,
  output gain_code_t       sel_o
);
  localparam int unsigned TAPS = 1 << DLY_W;

  gain_code_t tap [TAPS];
  gain_code_t dly_q [TAPS-1];

  assign tap[0] = code_i;

  for (genvar i = 0; i < TAPS - 1; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[i] <= '0;
      else         dly_q[i] <= tap[i];
    end
    assign tap[i+1] = dly_q[i];
  end

  assign sel_o = tap[dly_i];

  p_one_tap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_i == DLY_W'(1) |-> sel_o == $past(code_i));
endmodule

// File: rtl/agc_shift.sv
module agc_shift
  import agc_pkg::*;
#(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned OUT_W = IN_W + CODE_MAX
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  smp_i,
  input  gain_code_t              code_i,
  output logic signed [OUT_W-1:0] comp_o
);
  logic signed [OUT_W-1:0] ext;
  logic [CODE_W-1:0] shamt;

  assign ext   = {{(OUT_W-IN_W){smp_i[IN_W-1]}}, smp_i};
  assign shamt = CODE_W'(CODE_MAX) - code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_o <= '0;
    else         comp_o <= ext <<< shamt;
  end

  p_unity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i == gain_code_t'(CODE_MAX) |=> comp_o == OUT_W'($past(smp_i)) + '0
      || comp_o == {{(OUT_W-IN_W){$past(smp_i[IN_W-1])}}, $past(smp_i)});
  p_low_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (comp_o & OUT_W'((1 << ($past(shamt))) - 1)) == '0);
endmodule

// File: rtl/agc_comp.sv
module agc_comp
  import agc_pkg::*;
#(
  parameter int unsigned IN_W    = 14,
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned SH_W    = 4,
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned LEAK_SH = 8,
  localparam int unsigned OUT_W  = IN_W + CODE_MAX
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  smp_i,
  input  logic                    fixed_mode_i,
  input  logic [CODE_W-1:0]       fixed_code_i,
  input  logic [IN_W-2:0]         ref_lvl_i,
  input  logic [SH_W-1:0]         loop_shift_i,
  input  logic [DLY_W-1:0]        comp_dly_i,
  output logic [CODE_W-1:0]       gain_code_o,
  output logic                    gain_stb_o,
  output logic signed [OUT_W-1:0] comp_o
);
  gain_code_t cur_code, sel_code;

  agc_loop #(.IN_W(IN_W), .ACC_W(ACC_W), .SH_W(SH_W), .LEAK_SH(LEAK_SH)) u_loop (
    .clk_i, .rst_ni, .smp_i, .fixed_mode_i, .fixed_code_i,
    .ref_lvl_i, .loop_shift_i, .code_o(cur_code), .stb_o(gain_stb_o)
  );

  agc_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i, .rst_ni, .code_i(cur_code), .dly_i(comp_dly_i), .sel_o(sel_code)
  );

  agc_shift #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shift (
    .clk_i, .rst_ni, .smp_i, .code_i(sel_code), .comp_o
  );

  assign gain_code_o = cur_code;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (gain_code_o == '0 && !gain_stb_o && comp_o == '0));
endmodule

// File: tb/sim_agc_comp.sv
module sim_agc_comp;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic signed [13:0] s = '0;
  logic mode = 1'b0;
  logic [2:0] fc = '0;
  logic [12:0] rf = '0;
  logic [3:0] sh = '0, d = '0;
  logic [2:0] code;
  logic stb;
  logic signed [20:0] comp;

  int n_chk = 0, n_fail = 0;
  int m_acc = 0, m_prev = 0, e_comp = 0;
  int m_hist [16];
  string rq_code = "R3", rq_comp = "R6";
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  agc_comp u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(s), .fixed_mode_i(mode),
    .fixed_code_i(fc), .ref_lvl_i(rf), .loop_shift_i(sh), .comp_dly_i(d),
    .gain_code_o(code), .gain_stb_o(stb), .comp_o(comp)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int next_acc(int acc, bit fm, int fcode, int sv, int rv, int shv);
    int mag, err, sum;
    if (fm) return fcode << 13;
    mag = (sv < 0) ? -sv : sv;
    err = rv - mag;
    sum = acc - (acc >> 8) + (err >>> shv);
    if (sum < 0) sum = 0;
    if (sum > 65535) sum = 65535;
    return sum;
  endfunction

  // one sample clock: model update at the edge, compare at the falling edge
  task automatic cyc();
    int g, sel;
    @(posedge clk);
    g = m_acc >> 13;
    sel = (d == 0) ? g : m_hist[d-1];
    e_comp = int'(s) * (1 << (7 - sel));
    for (int i = 15; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = g;
    m_prev = g;
    m_acc = next_acc(m_acc, mode, int'(fc), int'(s), int'(rf), int'(sh));
    @(negedge clk);
    chk(rq_code, int'(code), m_acc >> 13);
    chk("R5", int'(stb), int'((m_acc >> 13) != m_prev));
    chk(rq_comp, int'(comp), e_comp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    foreach (m_hist[i]) m_hist[i] = 0;
    s = 14'sd5000; mode = 1; fc = 3'd5;
    repeat (3) @(negedge clk);
    chk("R1", int'(code), 0);
    chk("R1", int'(stb), 0);
    chk("R1", int'(comp), 0);
    rst_n = 1;

    // R2 / R8: fixed codes with full-scale samples
    rq_code = "R2"; rq_comp = "R8";
    for (int k = 0; k < 48; k++) begin
      fc = (k / 6 % 2) ? 3'd7 : 3'd0;
      case (k % 4)
        0: s = -14'sd8192;
        1: s = 14'sd8191;
        2: s = -14'sd1;
        default: s = 14'sd0;
      endcase
      cyc();
    end

    // R4: saturation high, then low
    rq_code = "R4"; rq_comp = "R6";
    mode = 0; rf = 13'd8191; sh = 4'd0; s = 0;
    repeat (60) cyc();
    chk("R4", int'(code), 7);
    rf = 13'd0;
    for (int k = 0; k < 80; k++) begin
      s = (k % 2) ? 14'sd8191 : -14'sd8192;
      cyc();
    end
    chk("R4", int'(code), 0);

    // R7: delay sweep with stepped fixed codes
    rq_code = "R2"; rq_comp = "R7";
    mode = 1;
    foreach (m_hist[i]) ;
    for (int j = 0; j < 4; j++) begin
      d = (j == 0) ? 4'd0 : (j == 1) ? 4'd1 : (j == 2) ? 4'd7 : 4'd15;
      for (int k = 0; k < 64; k++) begin
        if (k % 5 == 0) fc = 3'($urandom);
        s = 14'($urandom);
        cyc();
      end
    end

    // R3: random continuous loop mixed with mode and delay changes
    rq_code = "R3"; rq_comp = "R7";
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        rf = 13'($urandom); sh = 4'($urandom_range(0, 6));
        d = 4'($urandom);
      end
      mode = ($urandom_range(0, 99) < 5);
      fc = 3'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'($signed(13'($urandom)) >>> 3);
      cyc();
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule